// File: doc/BRIEF.md
# Multi-Channel Shared Memory Arbiter

This block lets several link channels reach one shared dual-port memory without help from a processor. Every channel owns two address generators. The generator with the even index writes what the channel receives. The generator with the odd index reads what the channel will send. A generator is given a start word address and a word count. It then requests one memory word at a time and steps its address up after each access. When its count reaches zero it raises a done flag.

A round-robin arbiter picks one pending generator per memory access. That generator then owns the bus for one to four bus cycles. The block drives a 16-bit word address and one of two bank chip selects, which the top address bit chooses. A configuration register sets the data bus width (8, 16 or 32 bits) and the byte order. The block splits each 32-bit word into bus beats to match that width, and swaps its bytes when big-endian order is selected.

Top module: `shmem_arbiter`

## Requirements
- R1: After reset, mem_en, mem_cs0, mem_cs1, xfer_done and every gen_done bit are low, and the configuration is 32-bit width (code 2) with little-endian order.
- R2: A start pulse loads a generator's base address and word count. Each completed access by that generator raises its address by one and lowers its count by one.
- R3: A generator's done bit goes high in the same cycle as the xfer_done of its last word. A start with count zero sets the done bit one cycle later and makes no memory access. Any accepted start with a nonzero count clears the done bit.
- R4: A start pulse to a generator that still has words left is ignored.
- R5: Requester 2c writes memory for channel c and requester 2c+1 reads memory for channel c. Priority rotates to the requester after the last one granted, and requester 0 has first priority after reset.
- R6: Each access takes one arbitration cycle, followed by 4, 2 or 1 bus cycles for width codes 0, 1 and 2 (code 3 acts as 2). mem_en is high through those bus cycles and mem_addr stays stable.
- R7: mem_sub gives the byte offset inside the word: the beat number in 8-bit mode, twice the beat number in 16-bit mode, and 0 in 32-bit mode.
- R8: During an access exactly one chip select is high: mem_cs0 when mem_addr[15] is 0, and mem_cs1 when it is 1.
- R9: In little-endian mode (cfg_big=0), beat k of a write puts W[k*w +: w] on mem_wdata[w-1:0], where w is the bus width, and the unused upper bits are zero. In big-endian mode the same rule applies to the byte-reversed word {W[7:0],W[15:8],W[23:16],W[31:24]}.
- R10: A read rebuilds the word by applying the R9 lane mapping in reverse. xfer_rdata is valid together with xfer_done, which pulses for one cycle after the last bus cycle and carries the requester in xfer_id.
- R11: The write word is taken from the channel's rx_wdata slice (channel c at bits 32c+31:32c) in the arbitration cycle. Later changes do not affect that access.
- R12: The width and byte-order settings are loaded from cfg_width and cfg_big on a clock edge where cfg_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the configuration register |
| cfg_width | input | 2 | Bus width code: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| cfg_big | input | 1 | 1 selects big-endian byte order |
| gen_start | input | 2*NCH | Start pulse, one bit per generator |
| gen_base | input | 2*NCH*AW | Start word address for each generator |
| gen_len | input | 2*NCH*LW | Word count for each generator |
| gen_done | output | 2*NCH | Done flag for each generator |
| rx_wdata | input | NCH*32 | Word to write, one slice per channel |
| mem_en | output | 1 | A bus cycle is active |
| mem_we | output | 1 | The active bus cycle is a write |
| mem_cs0 | output | 1 | Bank 0 select |
| mem_cs1 | output | 1 | Bank 1 select |
| mem_addr | output | AW | Word address |
| mem_sub | output | 2 | Byte offset inside the word |
| mem_wdata | output | 32 | Write data lanes |
| mem_rdata | input | 32 | Read data lanes, valid during the bus cycle |
| xfer_done | output | 1 | Pulses after each completed word access |
| xfer_id | output | $clog2(2*NCH) | Requester that completed the access |
| xfer_rdata | output | 32 | Rebuilt read word, valid with xfer_done |

## Verification
The main function is tried with every width code in both byte orders. Each word is written through a receive generator and read back through a transmit generator, at addresses in both banks. The byte image in the memory model separates a lane or swap error from an error in the rebuild path. Counting bus cycles per access separates the three width codes. A burst where all four generators start at once shows the rotation order and the done-flag timing. Directed cases cover a restart while busy, a zero count, and write data that changes while a word is on the bus.

// File: rtl/shmem_arbiter.sv
module shmem_arbiter #(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int LW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_width,
  input  logic                    cfg_big,
  input  logic [2*NCH-1:0]        gen_start,
  input  logic [2*NCH*AW-1:0]     gen_base,
  input  logic [2*NCH*LW-1:0]     gen_len,
  output logic [2*NCH-1:0]        gen_done,
  input  logic [NCH*32-1:0]       rx_wdata,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic                    mem_cs0,
  output logic                    mem_cs1,
  output logic [AW-1:0]           mem_addr,
  output logic [1:0]              mem_sub,
  output logic [31:0]             mem_wdata,
  input  logic [31:0]             mem_rdata,
  output logic                    xfer_done,
  output logic [$clog2(2*NCH)-1:0] xfer_id,
  output logic [31:0]             xfer_rdata
);
  localparam int NREQ = 2 * NCH;
  localparam int IW   = $clog2(NREQ);

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  logic [1:0]    width_q;
  logic          big_q;
  logic          busy;
  logic [IW-1:0] cur, last, win;
  logic [1:0]    beat;
  logic [AW-1:0] addr_q;
  logic [31:0]   wbuf, rbuf;
  logic [AW-1:0] g_addr [NREQ];
  logic [LW-1:0] g_cnt  [NREQ];
  logic [NREQ-1:0] req;
  logic          any;

  wire [1:0]  lastbeat = (width_q == 2'd0) ? 2'd3 : (width_q == 2'd1) ? 2'd1 : 2'd0;
  wire        fin      = busy && (beat == lastbeat);
  wire        grant    = !busy && any;
  wire [31:0] wsel     = rx_wdata[32*(int'(win)/2) +: 32];

  always_comb begin
    for (int i = 0; i < NREQ; i++) req[i] = (g_cnt[i] != '0);
  end

  always_comb begin
    int idx;
    any = 1'b0;
    win = '0;
    for (int k = 1; k <= NREQ; k++) begin
      idx = (int'(last) + k) % NREQ;
      if (!any && req[idx]) begin
        any = 1'b1;
        win = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q   <= 2'd2;
      big_q     <= 1'b0;
      busy      <= 1'b0;
      cur       <= '0;
      last      <= IW'(NREQ - 1);
      beat      <= '0;
      addr_q    <= '0;
      wbuf      <= '0;
      rbuf      <= '0;
      xfer_done <= 1'b0;
      xfer_id   <= '0;
      gen_done  <= '0;
      for (int i = 0; i < NREQ; i++) begin
        g_addr[i] <= '0;
        g_cnt[i]  <= '0;
      end
    end else begin
      if (cfg_we) begin
        width_q <= cfg_width;
        big_q   <= cfg_big;
      end
      xfer_done <= fin;
      if (grant) begin
        busy   <= 1'b1;
        cur    <= win;
        last   <= win;
        addr_q <= g_addr[win];
        wbuf   <= big_q ? bswap(wsel) : wsel;
        beat   <= '0;
      end else if (busy) begin
        case (width_q)
          2'd0:    rbuf[{beat, 3'b000} +: 8]     <= mem_rdata[7:0];
          2'd1:    rbuf[{beat[0], 4'b0000} +: 16] <= mem_rdata[15:0];
          default: rbuf <= mem_rdata;
        endcase
        beat <= beat + 2'd1;
        if (fin) begin
          busy    <= 1'b0;
          xfer_id <= cur;
        end
      end
      for (int i = 0; i < NREQ; i++) begin
        if (fin && cur == IW'(i)) begin
          g_addr[i] <= g_addr[i] + 1'b1;
          g_cnt[i]  <= g_cnt[i] - 1'b1;
          if (g_cnt[i] == LW'(1)) gen_done[i] <= 1'b1;
        end else if (gen_start[i] && g_cnt[i] == '0) begin
          g_addr[i]   <= gen_base[i*AW +: AW];
          g_cnt[i]    <= gen_len[i*LW +: LW];
          gen_done[i] <= (gen_len[i*LW +: LW] == '0);
        end
      end
    end
  end

  assign mem_en   = busy;
  assign mem_we   = busy && !cur[0];
  assign mem_addr = addr_q;
  assign mem_cs0  = busy && !addr_q[AW-1];
  assign mem_cs1  = busy && addr_q[AW-1];

  always_comb begin
    case (width_q)
      2'd0: begin
        mem_wdata = {24'b0, wbuf[{beat, 3'b000} +: 8]};
        mem_sub   = beat;
      end
      2'd1: begin
        mem_wdata = {16'b0, wbuf[{beat[0], 4'b0000} +: 16]};
        mem_sub   = {beat[0], 1'b0};
      end
      default: begin
        mem_wdata = wbuf;
        mem_sub   = 2'd0;
      end
    endcase
  end

  assign xfer_rdata = big_q ? bswap(rbuf) : rbuf;
endmodule

module shmem_arbiter_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_en,
  input logic          mem_cs0,
  input logic          mem_cs1,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_sub,
  input logic          xfer_done,
  input logic [1:0]    width_q
);
  assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ((mem_cs0 != mem_cs1) && (mem_cs1 == mem_addr[AW-1])));

  assert_no_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> (!mem_cs0 && !mem_cs1));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> $stable(mem_addr));

  assert_first_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en) |-> (mem_sub == 2'd0));

  assert_wide_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && width_q[1]) |-> (mem_sub == 2'd0));

  assert_done_after_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!mem_en && $past(mem_en)));
endmodule

bind shmem_arbiter shmem_arbiter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_cs0(mem_cs0), .mem_cs1(mem_cs1),
  .mem_addr(mem_addr), .mem_sub(mem_sub), .xfer_done(xfer_done), .width_q(width_q)
);

// File: tb/shmem_arbiter_bench.sv
`timescale 1ns/1ps
module shmem_arbiter_bench;
  localparam int NCH = 2, NREQ = 4, AW = 16, LW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_big = 0;
  logic [1:0] cfg_width = 2'd2;
  logic [NREQ-1:0] gen_start = '0;
  logic [NREQ*AW-1:0] gen_base = '0;
  logic [NREQ*LW-1:0] gen_len = '0;
  logic [NREQ-1:0] gen_done;
  logic [NCH*32-1:0] rx_wdata = '0;
  logic mem_en, mem_we, mem_cs0, mem_cs1, xfer_done;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_sub, xfer_id;
  logic [31:0] mem_wdata, mem_rdata, xfer_rdata;

  int nchk = 0, nfail = 0;
  logic [1:0] tbw = 2'd2;
  logic [7:0] mem [512][4];

  always #2 clk = ~clk;

  shmem_arbiter #(.NCH(NCH), .AW(AW), .LW(LW)) u_shmem_arbiter (.*);

  wire [8:0] mrow = {mem_cs1, mem_addr[7:0]};
  always_ff @(posedge clk) begin
    if (mem_en && mem_we) begin
      if (tbw == 2'd0) mem[mrow][mem_sub] <= mem_wdata[7:0];
      else if (tbw == 2'd1) begin
        mem[mrow][{mem_sub[1], 1'b0}] <= mem_wdata[7:0];
        mem[mrow][{mem_sub[1], 1'b1}] <= mem_wdata[15:8];
      end else for (int j = 0; j < 4; j++) mem[mrow][j] <= mem_wdata[8*j +: 8];
    end
  end
  always_comb begin
    if (tbw == 2'd0) mem_rdata = {24'b0, mem[mrow][mem_sub]};
    else if (tbw == 2'd1) mem_rdata = {16'b0, mem[mrow][{mem_sub[1], 1'b1}], mem[mrow][{mem_sub[1], 1'b0}]};
    else mem_rdata = {mem[mrow][3], mem[mrow][2], mem[mrow][1], mem[mrow][0]};
  end

  function automatic logic [31:0] swapb(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] rowv(input logic [15:0] a);
    logic [8:0] r = {a[15], a[7:0]};
    return {mem[r][3], mem[r][2], mem[r][1], mem[r][0]};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic start(input int g, input logic [15:0] base, input logic [15:0] len);
    gen_base[g*AW +: AW] = base;
    gen_len[g*LW +: LW] = len;
    gen_start[g] = 1'b1;
    @(negedge clk);
    gen_start[g] = 1'b0;
  endtask

  task automatic wait_xfer(output logic [1:0] id, output logic [31:0] d, output int ncyc);
    ncyc = 0;
    forever begin
      @(negedge clk);
      if (mem_en) ncyc++;
      if (xfer_done) break;
    end
    id = xfer_id;
    d = xfer_rdata;
  endtask

  task automatic wait_done(input int g);
    while (!gen_done[g]) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic b);
    cfg_width = w; cfg_big = b; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    tbw = (w == 2'd3) ? 2'd2 : w;
  endtask

  // width, big, address, word
  localparam logic [50:0] VEC [7] = '{
    {2'd0, 1'b0, 16'h0005, 32'h11223344},
    {2'd0, 1'b1, 16'h8006, 32'hA1B2C3D4},
    {2'd1, 1'b0, 16'h0007, 32'h55667788},
    {2'd1, 1'b1, 16'h8008, 32'h0BADF00D},
    {2'd2, 1'b0, 16'h0009, 32'hCAFEBABE},
    {2'd2, 1'b1, 16'h800A, 32'h13579BDF},
    {2'd3, 1'b1, 16'h000B, 32'h2468ACE0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [1:0] id;
    logic [31:0] d;
    int nc;
    for (int r = 0; r < 512; r++) for (int j = 0; j < 4; j++) mem[r][j] = 8'h00;
    repeat (3) @(negedge clk);
    check(!mem_en && !mem_cs0 && !mem_cs1 && !xfer_done && gen_done == 0, "R1 reset outputs",
          {26'b0, mem_en, mem_cs0, mem_cs1, xfer_done, 2'b0} | 32'(gen_done), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(!mem_en && gen_done == 0, "R1 idle after reset", 32'(mem_en), 32'h0);

    // R5 rotation with default 32-bit little-endian configuration (R1)
    rx_wdata = {32'hBBBB1111, 32'hAAAA0000};
    gen_base = {16'h0040, 16'h8030, 16'h0020, 16'h0010};
    gen_len = {16'd2, 16'd2, 16'd2, 16'd2};
    gen_start = 4'hF;
    @(negedge clk);
    gen_start = 4'h0;
    for (int n = 0; n < 8; n++) begin
      wait_xfer(id, d, nc);
      check(id == 2'(n % 4), "R5 grant order", 32'(id), 32'(n % 4));
      check(gen_done[id] == (n >= 4), "R3 done timing", 32'(gen_done[id]), 32'(n >= 4));
      check(nc == 1, "R1 default width 32 bus cycles", nc, 1);
    end
    check(rowv(16'h0010) == 32'hAAAA0000, "R2 R11 word 0", rowv(16'h0010), 32'hAAAA0000);
    check(rowv(16'h0011) == 32'hAAAA0000, "R2 address step", rowv(16'h0011), 32'hAAAA0000);
    check(rowv(16'h8031) == 32'hBBBB1111, "R8 bank 1 step", rowv(16'h8031), 32'hBBBB1111);
    check(rowv(16'h0031) == 32'h0, "R8 bank 0 untouched", rowv(16'h0031), 32'h0);
    check(gen_done == 4'hF, "R3 all done", 32'(gen_done), 32'hF);

    // R3 start clears done; zero count
    start(3, 16'h0041, 16'd1);
    check(gen_done[3] == 1'b0, "R3 start clears done", 32'(gen_done[3]), 32'h0);
    wait_done(3);
    start(2, 16'h0080, 16'd0);
    check(gen_done[2] == 1'b1, "R3 zero count done", 32'(gen_done[2]), 32'h1);
    nc = 0;
    repeat (6) begin @(negedge clk); if (mem_en) nc++; end
    check(nc == 0, "R3 zero count no access", nc, 0);

    // R4 restart while busy is ignored
    rx_wdata[31:0] = 32'h600D600D;
    start(0, 16'h0060, 16'd3);
    start(0, 16'h0070, 16'd1);
    wait_done(0);
    @(negedge clk);
    check(rowv(16'h0062) == 32'h600D600D, "R4 third word at old base", rowv(16'h0062), 32'h600D600D);
    check(rowv(16'h0070) == 32'h0, "R4 new base untouched", rowv(16'h0070), 32'h0);

    // R11 write word sampled at arbitration
    set_cfg(2'd0, 1'b0);
    rx_wdata[31:0] = 32'h01020304;
    start(0, 16'h0050, 16'd2);
    while (!mem_en) @(negedge clk);
    rx_wdata[31:0] = 32'hDEADDEAD;
    while (!xfer_done) @(negedge clk);
    rx_wdata[31:0] = 32'h0A0B0C0D;
    wait_done(0);
    @(negedge clk);
    check(rowv(16'h0050) == 32'h01020304, "R11 sampled at grant", rowv(16'h0050), 32'h01020304);
    check(rowv(16'h0051) == 32'h0A0B0C0D, "R11 second word", rowv(16'h0051), 32'h0A0B0C0D);

    // vector table: width and byte order (R6 R7 R9 R10 R12)
    for (int v = 0; v < 7; v++) begin
      logic [1:0] w;
      logic b;
      logic [15:0] a;
      logic [31:0] wd;
      int ebeats;
      {w, b, a, wd} = VEC[v];
      ebeats = (w == 2'd0) ? 4 : (w == 2'd1) ? 2 : 1;
      set_cfg(w, b);
      rx_wdata[31:0] = wd;
      start(0, a, 16'd1);
      wait_xfer(id, d, nc);
      check(nc == ebeats, "R6 R12 write bus cycles", nc, ebeats);
      @(negedge clk);
      check(rowv(a) == (b ? swapb(wd) : wd), "R9 R7 R8 memory bytes", rowv(a), b ? swapb(wd) : wd);
      start(1, a, 16'd1);
      wait_xfer(id, d, nc);
      check(nc == ebeats, "R6 read bus cycles", nc, ebeats);
      check(id == 2'd1, "R10 read id", 32'(id), 32'h1);
      check(d == wd, "R10 read word", d, wd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule